// File: doc/BRIEF.md
# Jitter Profile Delay-Code Sequencer

This block generates the stream of 10-bit control codes for a digitally programmed delay line, so that a clean clock passed through that line comes out with a chosen jitter waveform. A 50-sample waveform period is read out at a programmable sample rate, and each sample is scaled by an amplitude factor. The result is then offset to mid-scale so that negative jitter shortens the delay. The sample rate sets the jitter frequency (sample rate divided by 50). The amplitude factor sets the peak jitter in delay steps. The two settings are independent.

The waveform comes from one of two sources. The first is a built-in profile table: sinusoidal, uniform ramp, rectangular, alternating duty-cycle distortion or zero-mean pseudo-random. The second is a 50-entry buffer that the host loads with any summed waveform, for example a sine plus an alternating term. The profile, the source and the amplitude are picked up only at the start of a period, so every period that is emitted is complete.

Top module: `jitter_delay_seq`

## Requirements
- R1: While reset is asserted, and until the first sample is produced, `code_out` is 512, `code_stb` is 0 and `wr_done` is 0.
- R2: Samples are produced every D+1 clock cycles, where D = `ctrl_word[15:8]` as seen at the previous sample. `code_stb` is high for one cycle each time `code_out` takes a new sample.
- R3: The sample index runs 0..49 and wraps to 0 with no gap. With `ctrl_word[7]`=0, `ctrl_word[2:0]` picks a built-in table whose value s(k) at index k is as follows. For 0 (sine): 800*k*(25-k)/625 for k<25, and minus that formula applied to k-25 for k>=25, with truncating division. For 1 (uniform): 8*k-196. For 2 (rectangular): +200 for k<25, else -200. For 3 (alternating): -200 at even k, +200 at odd k. For 4 (random): for even k, ((23*k+7) mod 61)-30; for odd k, the negative of the preceding even entry. For 5 to 7: 0.
- R4: With F = `ctrl_word[23:16]` read as unsigned Q4.4, each code is 512 + floor((s*F + 8)/16).
- R5: Codes that would fall below 0 or above 1023 saturate at 0 or 1023.
- R6: Profile, source and amplitude are sampled from `ctrl_word` only while index 49 is produced, and they apply from the next index 0 onward. After reset these settings are all zero.
- R7: A `load_start` pulse clears `wr_done` and sets the write pointer to 0. Each `wr_en` cycle stores `wr_data` at the next buffer entry. `wr_done` rises in the cycle of the 50th store.
- R8: `wr_en` is ignored while `wr_done` is 1. Buffer contents do not change.
- R9: With the buffer selected (`ctrl_word[7]`=1) and `wr_done` low, every emitted code is 512.
- R10: With the buffer selected and `wr_done` high, buffer entry k is scaled as in R4 and R5 at index k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 24 | [2:0] profile, [7] buffer source, [15:8] rate divisor, [23:16] amplitude Q4.4 |
| load_start | input | 1 | Restart the buffer load |
| wr_en | input | 1 | Store wr_data into the buffer |
| wr_data | input | 10 | Signed buffer sample |
| code_out | output | 10 | Delay-line control code |
| code_stb | output | 1 | New code this cycle |
| wr_done | output | 1 | Buffer holds all 50 entries |

## Verification
The hardest behaviour to reach from the ports is a settings change that arrives in the middle of a period. Its effect appears only after index 49, and it has to be told apart from the old period still playing. The stimulus therefore changes the profile, amplitude and divisor at random times right after a sample, while a bench model follows the index and latches settings only at the wrap. The buffer source is taken through three states in turn: selected before loading, loaded, and hit with extra writes after it is full. Large amplitude factors drive both saturation limits.

// File: rtl/jds_pkg.sv
package jds_pkg;
  localparam int TAB_LEN_D = 50;
  localparam int SAMP_W_D  = 10;
  localparam int CODE_W_D  = 10;
  localparam int AMP_W_D   = 8;
  localparam int AMP_FRAC_D = 4;
  localparam int NUM_PROF  = 5;
  localparam int PEAK      = 200;

  typedef enum logic [2:0] {
    PROF_SINE = 3'd0,
    PROF_UNIF = 3'd1,
    PROF_RECT = 3'd2,
    PROF_ALT  = 3'd3,
    PROF_RAND = 3'd4
  } prof_e;

  function automatic int rand_raw(int k);
    return ((23 * k + 7) % 61) - 30;
  endfunction

  function automatic int tab_value(int prof, int k, int len);
    int h;
    h = len / 2;
    case (prof)
      0: begin
        if (k < h) return (4 * PEAK * k * (h - k)) / (h * h);
        else       return -((4 * PEAK * (k - h) * (len - k)) / (h * h));
      end
      1: return 8 * k - 4 * (len - 1);
      2: return (k < h) ? PEAK : -PEAK;
      3: return (k % 2 == 1) ? PEAK : -PEAK;
      4: return (k % 2 == 0) ? rand_raw(k) : -rand_raw(k - 1);
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/jds_rom.sv
module jds_rom #(
  parameter int TAB_LEN = jds_pkg::TAB_LEN_D,
  parameter int SAMP_W  = jds_pkg::SAMP_W_D,
  localparam int ADDR_W = $clog2(TAB_LEN)
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [2:0]               prof,
  output logic signed [SAMP_W-1:0] sample
);
  localparam int NP = jds_pkg::NUM_PROF;

  logic signed [SAMP_W-1:0] tab [NP][TAB_LEN];

  for (genvar p = 0; p < NP; p++) begin : g_prof
    for (genvar k = 0; k < TAB_LEN; k++) begin : g_ent
      assign tab[p][k] = SAMP_W'(jds_pkg::tab_value(p, k, TAB_LEN));
    end
  end

  always_comb begin
    sample = '0;
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < TAB_LEN; k++) begin
        if (prof == 3'(p) && addr == ADDR_W'(k)) sample = tab[p][k];
      end
    end
  end
endmodule

// File: rtl/jds_ram.sv
module jds_ram #(
  parameter int TAB_LEN = jds_pkg::TAB_LEN_D,
  parameter int SAMP_W  = jds_pkg::SAMP_W_D,
  localparam int ADDR_W = $clog2(TAB_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_start,
  input  logic                     wr_en,
  input  logic signed [SAMP_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [SAMP_W-1:0] rd_data,
  output logic                     wr_done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TAB_LEN - 1);

  logic signed [SAMP_W-1:0] mem [TAB_LEN];
  logic [ADDR_W-1:0] wp_q, wp_n;
  logic              done_q, done_n;
  logic              mem_we;

  assign mem_we = wr_en && !done_q && !load_start;

  always_comb begin
    wp_n   = wp_q;
    done_n = done_q;
    if (load_start) begin
      wp_n   = '0;
      done_n = 1'b0;
    end else if (mem_we) begin
      wp_n   = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      done_n = (wp_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      done_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wp_q] <= wr_data;
  end

  assign rd_data = (rd_addr <= LAST) ? mem[rd_addr] : '0;
  assign wr_done = done_q;

  assert_wp_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q <= LAST);
  assert_done_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done_q && !load_start && wp_q == LAST) |=> done_q);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load_start) |=> (done_q && $stable(wp_q)));
endmodule

// File: rtl/jds_scale.sv
module jds_scale #(
  parameter int SAMP_W   = jds_pkg::SAMP_W_D,
  parameter int AMP_W    = jds_pkg::AMP_W_D,
  parameter int AMP_FRAC = jds_pkg::AMP_FRAC_D,
  parameter int CODE_W   = jds_pkg::CODE_W_D
) (
  input  logic signed [SAMP_W-1:0] sample,
  input  logic [AMP_W-1:0]         amp,
  output logic [CODE_W-1:0]        code
);
  localparam int PW    = SAMP_W + AMP_W + 3;
  localparam int ROUND = 1 << (AMP_FRAC - 1);
  localparam int BIAS  = 1 << (CODE_W - 1);
  localparam int MAXC  = (1 << CODE_W) - 1;

  logic signed [PW-1:0] s_ext, a_ext, prod, rnd, biased;

  always_comb begin
    s_ext  = PW'(sample);
    a_ext  = PW'(amp);
    prod   = s_ext * a_ext;
    rnd    = (prod + PW'(ROUND)) >>> AMP_FRAC;
    biased = rnd + PW'(BIAS);
    if (biased < 0)                 code = '0;
    else if (biased > PW'(MAXC))    code = CODE_W'(MAXC);
    else                            code = biased[CODE_W-1:0];
  end
endmodule

// File: rtl/jitter_delay_seq.sv
module jitter_delay_seq #(
  parameter int TAB_LEN  = jds_pkg::TAB_LEN_D,
  parameter int SAMP_W   = jds_pkg::SAMP_W_D,
  parameter int CODE_W   = jds_pkg::CODE_W_D,
  parameter int AMP_W    = jds_pkg::AMP_W_D,
  parameter int AMP_FRAC = jds_pkg::AMP_FRAC_D,
  parameter int DIV_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [23:0]              ctrl_word,
  input  logic                     load_start,
  input  logic                     wr_en,
  input  logic signed [SAMP_W-1:0] wr_data,
  output logic [CODE_W-1:0]        code_out,
  output logic                     code_stb,
  output logic                     wr_done
);
  localparam int ADDR_W  = $clog2(TAB_LEN);
  localparam int SRC_BIT = 7;
  localparam int DIV_LO  = 8;
  localparam int AMP_LO  = 16;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TAB_LEN - 1);
  localparam logic [CODE_W-1:0] BIAS = CODE_W'(1 << (CODE_W - 1));

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [DIV_W-1:0]  div_q, div_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              src_q, src_n;
  logic [2:0]        prof_q, prof_n;
  logic [AMP_W-1:0]  amp_q, amp_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              stb_q, stb_n;
  logic              tick;

  logic signed [SAMP_W-1:0] rom_s, ram_s, sel_s;
  logic [CODE_W-1:0]        scaled;

  jds_rom #(.TAB_LEN(TAB_LEN), .SAMP_W(SAMP_W)) u_rom (
    .addr(addr_q), .prof(prof_q), .sample(rom_s)
  );

  jds_ram #(.TAB_LEN(TAB_LEN), .SAMP_W(SAMP_W)) u_ram (
    .clk(clk), .rst_n(rst_n_s), .load_start(load_start), .wr_en(wr_en),
    .wr_data(wr_data), .rd_addr(addr_q), .rd_data(ram_s), .wr_done(wr_done)
  );

  assign sel_s = src_q ? ram_s : rom_s;

  jds_scale #(.SAMP_W(SAMP_W), .AMP_W(AMP_W), .AMP_FRAC(AMP_FRAC), .CODE_W(CODE_W)) u_scale (
    .sample(sel_s), .amp(amp_q), .code(scaled)
  );

  assign tick = (div_q == '0);

  always_comb begin
    div_n  = div_q;
    addr_n = addr_q;
    src_n  = src_q;
    prof_n = prof_q;
    amp_n  = amp_q;
    code_n = code_q;
    stb_n  = 1'b0;
    if (tick) begin
      div_n  = ctrl_word[DIV_LO +: DIV_W];
      stb_n  = 1'b1;
      code_n = (src_q && !wr_done) ? BIAS : scaled;
      if (addr_q == LAST) begin
        addr_n = '0;
        src_n  = ctrl_word[SRC_BIT];
        prof_n = ctrl_word[2:0];
        amp_n  = ctrl_word[AMP_LO +: AMP_W];
      end else begin
        addr_n = addr_q + 1'b1;
      end
    end else begin
      div_n = div_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      div_q  <= '0;
      addr_q <= '0;
      src_q  <= 1'b0;
      prof_q <= '0;
      amp_q  <= '0;
      code_q <= BIAS;
      stb_q  <= 1'b0;
    end else begin
      div_q  <= div_n;
      addr_q <= addr_n;
      src_q  <= src_n;
      prof_q <= prof_n;
      amp_q  <= amp_n;
      code_q <= code_n;
      stb_q  <= stb_n;
    end
  end

  assign code_out = code_q;
  assign code_stb = stb_q;

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    addr_q <= LAST);
  assert_addr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick && addr_q == LAST) |=> (addr_q == '0));
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(tick && addr_q == LAST) |=> ($stable(prof_q) && $stable(amp_q) && $stable(src_q)));
  assert_blocked_bias_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick && src_q && !wr_done) |=> (code_out == BIAS));
  assert_zero_amp_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick && !src_q && amp_q == '0) |=> (code_out == BIAS));
endmodule

// File: tb/jitter_delay_seq_test.sv
`timescale 1ns/1ps
module jitter_delay_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] ctrl_word;
  logic        load_start, wr_en;
  logic signed [9:0] wr_data;
  logic [9:0]  code_out;
  logic        code_stb, wr_done;

  int checks = 0;
  int errors = 0;

  jitter_delay_seq uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .load_start(load_start),
    .wr_en(wr_en), .wr_data(wr_data), .code_out(code_out), .code_stb(code_stb),
    .wr_done(wr_done)
  );

  always #5 clk = ~clk;

  // bench-side model state
  logic [23:0] ctrl_q;
  logic [23:0] m_act;
  int          m_idx;
  int          m_ram [50];
  int          m_wp;
  logic        m_done;
  logic        extra_written;
  int          cyc, exp_gap;
  logic        have_prev;

  function automatic int btab(int p, int k);
    int v;
    case (p)
      0: return (k < 25) ? (800 * k * (25 - k)) / 625 : -((800 * (k - 25) * (50 - k)) / 625);
      1: return 8 * k - 196;
      2: return (k < 25) ? 200 : -200;
      3: return (k % 2 == 0) ? -200 : 200;
      4: begin
        if (k % 2 == 0) v = ((23 * k + 7) % 61) - 30;
        else            v = -(((23 * (k - 1) + 7) % 61) - 30);
        return v;
      end
      default: return 0;
    endcase
  endfunction

  function automatic int scale(int s, int f);
    int r;
    r = ((s * f + 8) >>> 4) + 512;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  function automatic logic clamps(int s, int f);
    int r;
    r = ((s * f + 8) >>> 4) + 512;
    return (r < 0) || (r > 1023);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) ctrl_q <= ctrl_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wp = 0; m_done = 1'b0;
    end else if (load_start) begin
      m_wp = 0; m_done = 1'b0;
    end else if (wr_en && !m_done) begin
      m_ram[m_wp] = int'(wr_data);
      if (m_wp == 49) begin m_done = 1'b1; m_wp = 0; end
      else m_wp = m_wp + 1;
    end
  end

  always @(negedge clk) begin
    int exp, s;
    string tag;
    if (!rst_n) begin
      m_act = '0; m_idx = 0; cyc = 0; have_prev = 1'b0;
    end else begin
      cyc++;
      if (code_stb) begin
        if (have_prev) check("R2 sample spacing", cyc, exp_gap);
        have_prev = 1'b1;
        exp_gap = int'(ctrl_q[15:8]) + 1;
        cyc = 0;
        if (m_act[7]) begin
          if (!m_done) begin
            exp = 512; tag = "R9";
          end else begin
            exp = scale(m_ram[m_idx], int'(m_act[23:16]));
            tag = extra_written ? "R8" : "R10";
          end
        end else begin
          s = btab(int'(m_act[2:0]), m_idx);
          exp = scale(s, int'(m_act[23:16]));
          if (clamps(s, int'(m_act[23:16]))) tag = "R5";
          else if (ctrl_q[23:16] != m_act[23:16] || ctrl_q[2:0] != m_act[2:0]) tag = "R6";
          else if (m_act[23:16] == 8'h10) tag = "R3";
          else tag = "R4";
        end
        check(tag, int'(code_out), exp);
        if (m_idx == 49) begin
          m_act = ctrl_q; m_idx = 0;
        end else m_idx++;
      end
    end
  end

  task automatic wait_samples(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!code_stb);
    end
  endtask

  task automatic drive_ctrl(logic [23:0] v);
    @(posedge clk); #1 ctrl_word = v;
  endtask

  task automatic write_one(int v);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = 10'(v);
    @(posedge clk); #1 wr_en = 1'b0;
    repeat ($urandom_range(2)) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    extra_written = 1'b0;
    rst_n = 1'b0; ctrl_word = '0; load_start = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset code", int'(code_out), 512);
    check("R1 reset strobe", int'(code_stb), 0);
    check("R1 reset done", int'(wr_done), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // directed: unit amplitude sine, full rate
    drive_ctrl({8'h10, 8'd0, 8'd0});
    wait_samples(110);
    // each profile at unit gain, one then with gaps
    for (int p = 1; p < 5; p++) begin
      drive_ctrl({8'h10, 8'(p % 3), 8'(p)});
      wait_samples(60);
    end
    // random settings changed mid-period
    for (int i = 0; i < 12; i++) begin
      drive_ctrl({8'($urandom_range(255)), 8'($urandom_range(3)), 5'd0, 3'($urandom_range(7))});
      wait_samples(20 + $urandom_range(60));
    end
    // saturation both ways
    drive_ctrl({8'hFF, 8'd1, 8'd0});
    wait_samples(110);
    drive_ctrl({8'hFF, 8'd0, 8'd3});
    wait_samples(60);

    // buffer selected before load: bias only
    drive_ctrl({8'h20, 8'd0, 8'h80});
    wait_samples(110);
    check("R7 done low before load", int'(wr_done), 0);
    drive_ctrl({8'h10, 8'd0, 8'd0});
    wait_samples(60);
    @(posedge clk); #1 load_start = 1'b1;
    @(posedge clk); #1 load_start = 1'b0;
    for (int k = 0; k < 50; k++) begin
      if (k == 49) begin @(negedge clk); check("R7 done before last", int'(wr_done), 0); end
      write_one(int'($urandom_range(600)) - 300);
    end
    @(negedge clk);
    check("R7 done after 50", int'(wr_done), 1);
    drive_ctrl({8'h18, 8'd1, 8'h80});
    wait_samples(110);
    // extra writes while full are ignored
    drive_ctrl({8'h10, 8'd0, 8'd0});
    wait_samples(60);
    for (int k = 0; k < 5; k++) write_one(123);
    @(negedge clk);
    check("R8 done stays high", int'(wr_done), 1);
    extra_written = 1'b1;
    drive_ctrl({8'h28, 8'd0, 8'h80});
    wait_samples(110);
    extra_written = 1'b0;
    // reload restart clears done
    drive_ctrl({8'h10, 8'd0, 8'd0});
    wait_samples(60);
    @(posedge clk); #1 load_start = 1'b1;
    @(posedge clk); #1 load_start = 1'b0;
    @(negedge clk);
    check("R7 restart clears done", int'(wr_done), 0);
    drive_ctrl({8'h10, 8'd0, 8'h80});
    wait_samples(60);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule